// File: doc/BRIEF.md
# Quad-Squaring Binary-Field Inverter

This block computes the multiplicative inverse of a nonzero element of GF(2^163), using the field polynomial x^163 + x^7 + x^6 + x^3 + 1. Elements are 163-bit polynomial-basis vectors, with bit i holding the coefficient of x^i. The inverse is found as A^(2^163 - 2). This exponent is built up along an addition chain that follows the binary digits of 162. Each step of the chain doubles or extends the run length k of an intermediate value A^(2^k - 1).

The datapath has one field multiplier, and a squarer sits directly on its output. In a single cycle it can therefore form a product, a plain square (the multiplier fed the same value twice), a fourth power (the same value twice, then the squarer), or a product followed by a squaring. Runs of squarings advance two powers per cycle. A run of odd length ends with a single plain square. The last multiplication of the chain absorbs the final squaring.

A caller pulses `start` with the operand present. One cycle later the block runs the whole chain by itself. It then raises `done` for one cycle, and `inverse` holds the result until the next computation finishes.

Top module: `gf_quad_inverter`

## Requirements
- R1: After synchronous reset, `done` is 0 and `inverse` is all zeros.
- R2: For any nonzero operand a, the result r satisfies r·a = 1 in GF(2^163) modulo x^163 + x^7 + x^6 + x^3 + 1, with bit i of each vector being the x^i coefficient.
- R3: An operand of 1 gives an inverse of 1.
- R4: `done` rises exactly 92 clock edges after the edge that samples `start`, and it stays high for exactly one cycle.
- R5: A `start` pulse during a computation is ignored. Neither the result nor the completion time of the computation in progress changes.
- R6: `inverse` keeps its value from one completion until the next one.
- R7: The operand x (only bit 1 set) gives x^162 + x^6 + x^5 + x^2 (bits 162, 6, 5 and 2 set).
- R8: Inverting a result returns the original operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an inversion of `operand` (sampled while idle) |
| operand | input | 163 | Nonzero field element to invert |
| done | output | 1 | One-cycle pulse when `inverse` is updated |
| inverse | output | 163 | Most recent inverse, held between completions |

## Verification
The inverter is exercised with several kinds of operand: the identity, the single-term element x, the top-degree term x^162, a dense all-ones vector, a sparse two-term vector and a series of random vectors. The identity and x have inverses known in closed form, so they expose errors in the chain order or in the reduction taps. The top-degree and dense operands stress the reduction of every overflow position. Random operands, checked through the product with the operand and through double inversion, catch odd-length runs mishandled as even ones. A start pulse in the middle of a run, and idle cycles after completion, separate a correctly held result from a restarted or overwritten one.

// File: rtl/gfinv_pkg.sv
package gfinv_pkg;

  localparam int FIELD_M = 163;
  localparam logic [FIELD_M-1:0] FIELD_TAPS = FIELD_M'('hC9);

  typedef enum logic [2:0] {
    OP_NONE,
    OP_LOAD,
    OP_QUAD,
    OP_SQ1,
    OP_MULS,
    OP_MULA
  } gfinv_op_e;

  typedef enum logic [1:0] {
    PH_DSQ,
    PH_DMUL,
    PH_ISQ,
    PH_IMUL
  } gfinv_phase_e;

  // Cycles spent in the run state for a field of degree m.
  function automatic int inv_cycles(input int m);
    int n;
    int k;
    int c;
    n = m - 1;
    k = 1;
    c = 0;
    for (int b = $clog2(m) - 2; b >= 0; b--) begin
      c = c + (k + 1) / 2 + 1;
      k = k * 2;
      if (((n >> b) & 1) == 1) begin
        c = c + 2;
        k = k + 1;
      end
    end
    return c;
  endfunction

endpackage

// File: rtl/gfinv_mul.sv
module gfinv_mul #(
  parameter int M = gfinv_pkg::FIELD_M,
  parameter logic [M-1:0] TAPS = gfinv_pkg::FIELD_TAPS
) (
  input  logic [M-1:0] a,
  input  logic [M-1:0] b,
  output logic [M-1:0] p
);
  // MSB-first shift-and-add with reduction interleaved in every step.
  always_comb begin
    logic [M-1:0] acc;
    acc = '0;
    for (int i = M - 1; i >= 0; i--) begin
      acc = {acc[M-2:0], 1'b0} ^ (acc[M-1] ? TAPS : '0);
      if (b[i]) acc = acc ^ a;
    end
    p = acc;
  end
endmodule

// File: rtl/gfinv_sqr.sv
module gfinv_sqr #(
  parameter int M = gfinv_pkg::FIELD_M,
  parameter logic [M-1:0] TAPS = gfinv_pkg::FIELD_TAPS
) (
  input  logic [M-1:0] a,
  output logic [M-1:0] y
);
  localparam int WW = 2 * M - 1;

  logic [WW-1:0] spread;

  // Zero bit placed between neighbouring input bits.
  generate
    for (genvar g = 0; g < M; g++) begin : g_spread
      assign spread[2*g] = a[g];
      if (g < M - 1) begin : g_gap
        assign spread[2*g+1] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    logic [WW-1:0] w;
    w = spread;
    for (int i = WW - 1; i >= M; i--) begin
      if (w[i]) begin
        w[i] = 1'b0;
        w = w ^ ({{(M-1){1'b0}}, TAPS} << (i - M));
      end
    end
    y = w[M-1:0];
  end
endmodule

// File: rtl/gfinv_ctrl.sv
module gfinv_ctrl
  import gfinv_pkg::*;
#(
  parameter int M = FIELD_M
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  output gfinv_op_e op,
  output logic      fin,
  output logic      done
);
  localparam int BW  = $clog2(M);
  localparam int KW  = $clog2(M + 1);
  localparam logic [BW-1:0] NVAL = BW'(M - 1);
  localparam int TOPBIT = $clog2(M) - 1;
  localparam int LAT = inv_cycles(M);
  localparam int CW = $clog2(LAT + 1) + 1;

  logic         busy_q, busy_n;
  gfinv_phase_e ph_q, ph_n;
  logic [BW-1:0] bit_q, bit_n;
  logic [KW-1:0] k_q, k_n;
  logic [KW-1:0] rem_q, rem_n;
  logic          done_q;
  logic [CW-1:0] cyc_q;

  always_comb begin
    op     = OP_NONE;
    fin    = 1'b0;
    busy_n = busy_q;
    ph_n   = ph_q;
    bit_n  = bit_q;
    k_n    = k_q;
    rem_n  = rem_q;
    if (!busy_q) begin
      if (start) begin
        op     = OP_LOAD;
        busy_n = 1'b1;
        bit_n  = BW'(TOPBIT - 1);
        k_n    = KW'(1);
        rem_n  = KW'(1);
        ph_n   = PH_DSQ;
      end
    end else begin
      unique case (ph_q)
        PH_DSQ: begin
          if (rem_q >= KW'(2)) begin
            op    = OP_QUAD;
            rem_n = rem_q - KW'(2);
          end else begin
            op    = OP_SQ1;
            rem_n = '0;
          end
          if (rem_n == '0) ph_n = PH_DMUL;
        end
        PH_DMUL: begin
          op  = OP_MULS;
          k_n = k_q << 1;
          if (bit_q == '0 && !NVAL[0]) begin
            fin    = 1'b1;
            busy_n = 1'b0;
          end else if (NVAL[bit_q]) begin
            ph_n = PH_ISQ;
          end else begin
            bit_n = bit_q - BW'(1);
            rem_n = k_q << 1;
            ph_n  = PH_DSQ;
          end
        end
        PH_ISQ: begin
          op   = OP_SQ1;
          ph_n = PH_IMUL;
        end
        default: begin
          op  = OP_MULA;
          k_n = k_q + KW'(1);
          if (bit_q == '0) begin
            fin    = 1'b1;
            busy_n = 1'b0;
          end else begin
            bit_n = bit_q - BW'(1);
            rem_n = k_q + KW'(1);
            ph_n  = PH_DSQ;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      ph_q   <= PH_DSQ;
      bit_q  <= '0;
      k_q    <= '0;
      rem_q  <= '0;
      done_q <= 1'b0;
      cyc_q  <= '0;
    end else begin
      busy_q <= busy_n;
      ph_q   <= ph_n;
      bit_q  <= bit_n;
      k_q    <= k_n;
      rem_q  <= rem_n;
      done_q <= fin;
      if (op == OP_LOAD) cyc_q <= '0;
      else if (busy_q)   cyc_q <= cyc_q + CW'(1);
    end
  end

  assign done = done_q;

  // R4: the finishing operation lands on the last cycle of the fixed schedule
  assert_latency_R4: assert property (@(posedge clk) disable iff (rst)
    fin |-> cyc_q == CW'(LAT - 1));

  // R4: completion is a single-cycle pulse
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5: a start seen mid-run does not restart the schedule
  assert_ignore_start_R5: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start && !fin) |=> cyc_q == $past(cyc_q) + CW'(1));

  // R2: a squaring run is never entered with nothing left to square
  assert_run_nonempty_R2: assert property (@(posedge clk) disable iff (rst)
    (busy_q && ph_q == PH_DSQ) |-> rem_q != '0);

endmodule

// File: rtl/gfinv_dp.sv
module gfinv_dp
  import gfinv_pkg::*;
#(
  parameter int M = FIELD_M,
  parameter logic [M-1:0] TAPS = FIELD_TAPS
) (
  input  logic         clk,
  input  logic         rst,
  input  gfinv_op_e    op,
  input  logic         fin,
  input  logic [M-1:0] operand,
  output logic [M-1:0] inv
);
  logic [M-1:0] t_q, s_q, a_q, inv_q;
  logic [M-1:0] mul_b, prod, prod_sq;

  always_comb begin
    unique case (op)
      OP_MULS: mul_b = s_q;
      OP_MULA: mul_b = a_q;
      default: mul_b = t_q;
    endcase
  end

  gfinv_mul #(.M(M), .TAPS(TAPS)) u_mul (.a(t_q), .b(mul_b), .p(prod));
  gfinv_sqr #(.M(M), .TAPS(TAPS)) u_sqr (.a(prod), .y(prod_sq));

  always_ff @(posedge clk) begin
    if (rst) begin
      t_q   <= '0;
      s_q   <= '0;
      a_q   <= '0;
      inv_q <= '0;
    end else begin
      unique case (op)
        OP_LOAD: begin
          t_q <= operand;
          s_q <= operand;
          a_q <= operand;
        end
        OP_QUAD: t_q <= prod_sq;
        OP_SQ1:  t_q <= prod;
        OP_MULS, OP_MULA: begin
          if (fin) inv_q <= prod_sq;
          else begin
            t_q <= prod;
            s_q <= prod;
          end
        end
        default: ;
      endcase
    end
  end

  assign inv = inv_q;

  // R6: the result register moves only on the finishing operation
  assert_inv_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !fin |=> $stable(inv_q));

  // R3: the identity maps to itself
  assert_one_fixed_R3: assert property (@(posedge clk) disable iff (rst)
    (fin && a_q == M'(1)) |=> inv_q == M'(1));

endmodule

// File: rtl/gf_quad_inverter.sv
module gf_quad_inverter
  import gfinv_pkg::*;
#(
  parameter int M = FIELD_M,
  parameter logic [M-1:0] TAPS = FIELD_TAPS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [M-1:0] operand,
  output logic         done,
  output logic [M-1:0] inverse
);
  gfinv_op_e op;
  logic      fin;

  gfinv_ctrl #(.M(M)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .op(op), .fin(fin), .done(done)
  );

  gfinv_dp #(.M(M), .TAPS(TAPS)) u_dp (
    .clk(clk), .rst(rst), .op(op), .fin(fin),
    .operand(operand), .inv(inverse)
  );

  // R1: nothing reported straight out of reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!done && inverse == '0));

endmodule

// File: tb/gf_quad_inverter_tb.sv
module gf_quad_inverter_tb;
  localparam int W = 163;
  localparam int EXP_LAT = 92;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [W-1:0] operand = '0;
  logic done;
  logic [W-1:0] inverse;

  int checks = 0;
  int errors = 0;
  int wd = 0;

  always #10 clk = ~clk;

  gf_quad_inverter u_dut (
    .clk(clk), .rst(rst), .start(start),
    .operand(operand), .done(done), .inverse(inverse)
  );

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      errors++;
      $display("FAIL watchdog R4 actual %0d expected below 150000 cycles", wd);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Full product, then fold the overflow with x^163 = x^7 + x^6 + x^3 + 1.
  function automatic logic [W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [2*W-2:0] p;
    p = '0;
    for (int i = 0; i < W; i++)
      if (b[i]) p = p ^ ({{(W-1){1'b0}}, a} << i);
    for (int i = 2*W-2; i >= W; i--) begin
      if (p[i]) begin
        p[i] = 1'b0;
        p[i-W+7] = ~p[i-W+7];
        p[i-W+6] = ~p[i-W+6];
        p[i-W+3] = ~p[i-W+3];
        p[i-W]   = ~p[i-W];
      end
    end
    return p[W-1:0];
  endfunction

  function automatic logic [W-1:0] rand_elem();
    logic [W-1:0] v;
    v = '0;
    for (int i = 0; i < 6; i++) v = (v << 32) | W'($urandom);
    if (v == '0) v = W'(1);
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Runs one inversion; optionally pulses a second start at cycle intr_at.
  task automatic run_inv(input logic [W-1:0] v, input int intr_at, input logic [W-1:0] v2,
                         output logic [W-1:0] res, output int lat);
    int cnt;
    @(negedge clk);
    start = 1'b1;
    operand = v;
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    while (!done && cnt < 400) begin
      if (cnt == intr_at) begin
        start = 1'b1;
        operand = v2;
      end
      @(negedge clk);
      start = 1'b0;
      cnt++;
    end
    res = inverse;
    lat = cnt;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(done == 1'b0, "R1 done after reset", W'(done), '0);
    chk(inverse == '0, "R1 inverse after reset", inverse, '0);
  endtask

  task automatic t_one();
    logic [W-1:0] r;
    int lat;
    run_inv(W'(1), -1, '0, r, lat);
    chk(r == W'(1), "R3 inverse of one", r, W'(1));
    chk(lat == EXP_LAT, "R4 latency", W'(lat), W'(EXP_LAT));
  endtask

  task automatic t_x();
    logic [W-1:0] r, e;
    int lat;
    e = (W'(1) << 162) | W'('h64);
    run_inv(W'(2), -1, '0, r, lat);
    chk(r == e, "R7 inverse of x", r, e);
    @(negedge clk);
    chk(done == 1'b0, "R4 done single pulse", W'(done), '0);
  endtask

  task automatic t_pattern(input logic [W-1:0] v, input string tag);
    logic [W-1:0] r, p;
    int lat;
    run_inv(v, -1, '0, r, lat);
    p = ref_mul(r, v);
    chk(p == W'(1), $sformatf("R2 product with operand (%s)", tag), p, W'(1));
    chk(lat == EXP_LAT, $sformatf("R4 latency (%s)", tag), W'(lat), W'(EXP_LAT));
  endtask

  task automatic t_hold();
    logic [W-1:0] r, p;
    int lat;
    bit seen;
    run_inv(rand_elem(), -1, '0, r, lat);
    seen = 1'b0;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    chk(inverse == r, "R6 inverse held while idle", inverse, r);
    chk(seen == 1'b0, "R6 no extra completion", W'(seen), '0);
  endtask

  task automatic t_ignore();
    logic [W-1:0] v1, v2, r, p;
    int lat;
    v1 = rand_elem();
    v2 = rand_elem() ^ W'(8);
    run_inv(v1, 30, v2, r, lat);
    p = ref_mul(r, v1);
    chk(p == W'(1), "R5 result belongs to first operand", p, W'(1));
    chk(lat == EXP_LAT, "R5 completion time unchanged", W'(lat), W'(EXP_LAT));
  endtask

  task automatic t_invol();
    logic [W-1:0] v, r1, r2;
    int lat;
    v = rand_elem();
    run_inv(v, -1, '0, r1, lat);
    run_inv(r1, -1, '0, r2, lat);
    chk(r2 == v, "R8 double inversion", r2, v);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_one();
    t_x();
    t_pattern(W'(1) << 162, "top term");
    t_pattern({W{1'b1}}, "all ones");
    t_pattern((W'(1) << 100) | W'(1), "sparse");
    for (int i = 0; i < 6; i++) t_pattern(rand_elem(), "random");
    t_hold();
    t_ignore();
    t_invol();
    t_invol();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule